// File: doc/BRIEF.md
# Packed Signed Halving Subtractor

This block is a SIMD datapath stage. It takes two 32-bit operand words and splits each one into signed lanes. A single mode bit picks the lane size: either two 16-bit lanes or four 8-bit lanes. In every lane it forms the first operand minus the second and halves the difference with an arithmetic right shift. It packs the halved lane results back into one 32-bit word, and each result goes to the position its lane came from.

Each lane subtraction is done one bit wider than the lane. Because of this, the halved result always fits in the lane width and can never wrap or saturate. The unit takes a valid-qualified request and returns a registered, valid-qualified result one clock later. It has no flag or status outputs.

Top module: `psh_sub_halve`

## Requirements
- R1: With `in_mode` = 0, the word holds two 16-bit signed lanes. Lane 0 is bits [15:0] and lane 1 is bits [31:16]. Each result lane equals floor((A_lane − B_lane) / 2), written to the same bit positions.
- R2: With `in_mode` = 1, the word holds four 8-bit signed lanes. Lane k is bits [8k+7:8k]. Each result lane equals floor((A_lane − B_lane) / 2), written to the same bit positions.
- R3: The operand order is fixed: `in_a` lane minus `in_b` lane, never the reverse.
- R4: An odd difference rounds toward negative infinity. For example, a difference of −1 gives −1 and a difference of +1 gives 0.
- R5: No borrow passes from one lane into the next, in either mode.
- R6: No overflow occurs at the extremes. The most negative lane value minus the most positive gives the most negative value (0x8000 or 0x80). The most positive minus the most negative gives the most positive value (0x7FFF or 0x7F).
- R7: `out_valid` equals `in_valid` delayed by one clock. `out_data` shows the result of an operation one clock after that operation is presented.
- R8: `out_data` holds its value in any cycle in which `in_valid` is low.
- R9: A synchronous active-low reset clears `out_valid` and `out_data` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request qualifier |
| in_mode | input | 1 | Lane size: 0 = two 16-bit lanes, 1 = four 8-bit lanes |
| in_a | input | 32 | First operand (minuend) |
| in_b | input | 32 | Second operand (subtrahend) |
| out_valid | output | 1 | Result qualifier, one clock after `in_valid` |
| out_data | output | 32 | Packed halved differences |

## Verification
The byte mode is swept over every pair of 8-bit values, with each lane fed a different mix of the pair. A design that let a borrow cross a lane boundary, or that halved a lane-width difference that had already wrapped, would show mismatches in neighbouring lanes or at the extremes. Dedicated cases target the 0x80/0x7F and 0x8000/0x7FFF extremes, where a lane computed without the extra bit returns a result of the wrong sign. They also target differences of ±1, where a design that rounds toward zero returns 0 instead of −1. A case with swapped operands catches a design that subtracts in the wrong order. Pseudo-random halfword traffic and idle cycles with changed operands check the one-cycle latency and the holding of the output register.

// File: rtl/psh_pkg.sv
// Shared definitions for the packed signed halving subtractor.
// Assumes a word that is a whole multiple of both lane widths.
package psh_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned BYTE_W = 8;

    // Lane size selection as seen on the mode pin.
    typedef enum logic {
        LANES_HALF = 1'b0,
        LANES_BYTE = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/psh_lane.sv
// One signed lane: res = floor((a - b) / 2).
// Both operands are sign-extended by one bit, so the difference is exact
// and its upper W bits form the halved result without any overflow.
module psh_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    logic [W:0]   diff;
    logic [W+1:0] diff_x;
    logic [W+1:0] twice_res;
    logic [W+1:0] remainder;

    // Extended-precision subtraction; the lane's own carry chain only.
    always_comb diff = {a[W-1], a} - {b[W-1], b};

    // Halve by dropping the low bit (arithmetic shift, floor rounding).
    always_comb res = diff[W:1];

    // Check values: the remainder of the halving must be 0 or 1.
    always_comb begin
        diff_x    = {diff[W], diff};
        twice_res = {res[W-1], res, 1'b0};
        remainder = diff_x - twice_res;
    end

    // Floor rounding: diff - 2*res lies in {0,1} (R4).
    always_comb begin
        p_floor_half_r4: assert (remainder == '0 || remainder == {{(W+1){1'b0}}, 1'b1})
            else $error("lane halving remainder out of range");
    end

    // Extremes must not wrap (R6).
    always_comb begin
        if (a == MIN_V && b == MAX_V) begin
            p_no_overflow_lo_r6: assert (res == MIN_V)
                else $error("min-max did not give min");
        end
        if (a == MAX_V && b == MIN_V) begin
            p_no_overflow_hi_r6: assert (res == MAX_V)
                else $error("max-min did not give max");
        end
    end
endmodule

// File: rtl/psh_lane_array.sv
// A row of independent signed halving-subtract lanes spanning one word.
// Lane 0 sits at the least significant bits; no borrow crosses lanes.
module psh_lane_array #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] res
);
    localparam int unsigned LANES = WORD_W / LANE_W;

    // One lane instance per slice of the word.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        psh_lane #(.W(LANE_W)) u_lane (
            .a  (a[k*LANE_W +: LANE_W]),
            .b  (b[k*LANE_W +: LANE_W]),
            .res(res[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/psh_out_reg.sv
// Output stage: valid follows the request by one clock; data loads only
// on a valid request and holds otherwise. Synchronous active-low reset.
module psh_out_reg #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [WORD_W-1:0] d_data,
    output logic              q_valid,
    output logic [WORD_W-1:0] q_data
);
    // Capture the result word and delay the qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_data <= d_data;
            end
        end
    end
endmodule

// File: rtl/psh_sub_halve.sv
// Packed signed halving subtractor, top level.
// Computes both lane layouts in parallel and selects one by the mode pin,
// which is sampled together with the operands. One cycle of latency.
module psh_sub_halve
    import psh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_mode,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    output logic        out_valid,
    output logic [31:0] out_data
);
    lane_mode_e        mode;
    logic [WORD_W-1:0] half_res;
    logic [WORD_W-1:0] byte_res;
    logic [WORD_W-1:0] sel_res;

    // Interpret the mode pin.
    always_comb mode = lane_mode_e'(in_mode);

    psh_lane_array #(.WORD_W(WORD_W), .LANE_W(HALF_W)) u_half (
        .a  (in_a),
        .b  (in_b),
        .res(half_res)
    );

    psh_lane_array #(.WORD_W(WORD_W), .LANE_W(BYTE_W)) u_byte (
        .a  (in_a),
        .b  (in_b),
        .res(byte_res)
    );

    // Pick the lane layout requested for this operation.
    always_comb sel_res = (mode == LANES_BYTE) ? byte_res : half_res;

    psh_out_reg #(.WORD_W(WORD_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_valid(in_valid),
        .d_data (sel_res),
        .q_valid(out_valid),
        .q_data (out_data)
    );

    // A request yields a valid result next cycle (R7).
    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // No request means no valid result next cycle (R7).
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Idle cycles leave the result word untouched (R8).
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: tb/psh_sub_halve_tb.sv
module psh_sub_halve_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    psh_sub_halve u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
    );

    // Independent arithmetic model: per-lane floor((a-b)/2).
    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic m);
        int w;
        int n;
        logic [31:0] r;
        w = m ? 8 : 16;
        n = 32 / w;
        r = '0;
        for (int k = 0; k < n; k++) begin
            int ua;
            int ub;
            int d;
            ua = int'((a >> (k * w)) & ((32'd1 << w) - 1));
            ub = int'((b >> (k * w)) & ((32'd1 << w) - 1));
            if (ua >= (1 << (w - 1))) ua -= (1 << w);
            if (ub >= (1 << (w - 1))) ub -= (1 << w);
            d = (ua - ub) >>> 1;
            r |= (32'(d) & ((32'd1 << w) - 1)) << (k * w);
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Present one operation at a falling edge; check one cycle later.
    task automatic op(string req, logic [31:0] a, logic [31:0] b, logic m);
        in_valid = 1'b1;
        in_mode  = m;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, out_data, model(a, b, m));
    endtask

    task automatic op_exp(string req, logic [31:0] a, logic [31:0] b, logic m,
                          logic [31:0] exp);
        in_valid = 1'b1;
        in_mode  = m;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        check(req, out_data, exp);
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] held;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset data", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: extremes in both modes
        op_exp("R6 half min-max", 32'h8000_8000, 32'h7FFF_7FFF, 1'b0, 32'h8000_8000);
        op_exp("R6 half max-min", 32'h7FFF_7FFF, 32'h8000_8000, 1'b0, 32'h7FFF_7FFF);
        op_exp("R6 byte min-max", 32'h8080_8080, 32'h7F7F_7F7F, 1'b1, 32'h8080_8080);
        op_exp("R6 byte max-min", 32'h7F7F_7F7F, 32'h8080_8080, 1'b1, 32'h7F7F_7F7F);
        // R4: rounding toward negative infinity
        op_exp("R4 half -1/+1", 32'h0001_0000, 32'h0000_0001, 1'b0, 32'h0000_FFFF);
        op_exp("R4 byte -1", 32'h0000_0000, 32'h0101_0101, 1'b1, 32'hFFFF_FFFF);
        op_exp("R4 byte -3", 32'h0000_0000, 32'h0303_0303, 1'b1, 32'hFEFE_FEFE);
        // R3: operand order
        op_exp("R3 half order", 32'h0010_0064, 32'h0004_0000, 1'b0, 32'h0006_0032);
        op_exp("R3 byte order", 32'h0000_0000, 32'h0A0A_0A0A, 1'b1, 32'hFBFB_FBFB);
        // R5: no borrow across lanes
        op_exp("R5 half borrow", 32'h0000_0000, 32'h0000_0002, 1'b0, 32'h0000_FFFF);
        op_exp("R5 byte borrow", 32'h0000_0000, 32'h0000_0200, 1'b1, 32'h0000_FF00);
        op_exp("R5 byte mode vs half", 32'h0000_0100, 32'h0000_0002, 1'b1, 32'h0000_00FF);

        // R8: hold while idle, R7: valid drops
        held = out_data;
        in_valid = 1'b0;
        in_a = 32'hDEAD_BEEF;
        in_b = 32'h1234_5678;
        in_mode = 1'b1;
        @(negedge clk);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);
        check("R8 hold data", out_data, held);
        @(negedge clk);
        check("R8 hold data 2", out_data, held);

        // R2: exhaustive byte sweep, distinct mix per lane
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                logic [7:0] x;
                logic [7:0] y;
                x = 8'(i);
                y = 8'(j);
                op("R2 byte sweep", {~x, x ^ 8'h5A, y, x}, {y + 8'd3, y, x, y}, 1'b1);
            end
        end

        // R1 and R7: pseudo-random halfword traffic, back to back
        lfsr = 32'hACE1_1234;
        for (int t = 0; t < 20000; t++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op("R1 half random", a, lfsr, 1'b0);
        end

        in_valid = 1'b0;
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule